// File: doc/BRIEF.md
# Self-Referenced Bit-Flipping Memory

This block wraps a single-port, synchronous storage array and evens out how many ones and zeros the array cells hold over time. Cells that keep one value for long periods age faster. The block therefore decides, word by word, whether to store the data bits inverted. The decision comes from one chosen bit of the word being written, called the flip bit.

The flip bit is written into the array unchanged. When the word is read back, that same stored bit shows whether the other bits were inverted, and the block undoes the inversion. No extra column holds an inversion flag, so the array is exactly as wide as the data. The user sees a plain memory with one cycle of read latency. A debug output shows the raw word as it sits in the array.

Top module: `flipmem_top`

## Requirements
- R1: When the flip bit of the written word is 0, the word is stored exactly as written; a later read of that address shows the same value on `raw_dbg`.
- R2: When the flip bit of the written word is 1, every bit except the flip bit is stored inverted, so `raw_dbg` equals the written word XOR a mask that has all bits set except bit `FLIP_POS`.
- R3: The flip bit itself is never inverted, and `raw_dbg[FLIP_POS]` always equals `rd_data[FLIP_POS]`.
- R4: A read with `rd_en` high at clock edge k shows, after edge k, the last word written to that address on `rd_data`, for both flip-bit values, all-zero and all-one words included.
- R5: When a read and a write to the same address happen on the same edge, `rd_data` returns the word stored before that write.
- R6: While `rd_en` is low, `rd_data` and `raw_dbg` hold their values, even across writes.
- R7: A synchronous reset (`rst_n` low at an edge) clears `rd_data` and `raw_dbg` to zero and leaves the array contents intact.
- R8: The flip-bit position is the parameter `FLIP_POS`, which defaults to `DATA_W-1`. The array holds exactly `DATA_W` bits per word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the read path |
| wr_en | input | 1 | Write the word on `wr_data` to `addr` |
| rd_en | input | 1 | Read `addr`; result appears after the edge |
| addr | input | $clog2(DEPTH) | Word address shared by read and write |
| wr_data | input | DATA_W | Word to write |
| rd_data | output | DATA_W | Decoded word, equal to what was written |
| raw_dbg | output | DATA_W | Raw word as held in the array |

## Verification
On every cycle, the assertions check three things: the flip bit matches between the raw and decoded read outputs, the two outputs differ by exactly the inversion mask or not at all, and both outputs stay unchanged while no read occurs and clear after reset. Other behaviours need a history of writes and reads, so only the bench's scenarios can show them. These are the round trip through the array, the inverted storage pattern, the old-data result of a same-address read and write, and the retention of array contents across reset. The bench sweeps every word value of a small 8-bit configuration with the flip bit moved off the top bit, across all addresses.

// File: rtl/flipmem_pkg.sv
// Package flipmem_pkg
// Shared helpers for the bit-flipping memory. Assumes DATA_W <= MAX_W.
package flipmem_pkg;

    localparam int unsigned MAX_W = 64;

    // Mask with every bit set except the flip-bit position.
    function automatic logic [MAX_W-1:0] data_mask(input int unsigned pos);
        logic [MAX_W-1:0] m;
        m = '1;
        m[pos] = 1'b0;
        return m;
    endfunction

endpackage

// File: rtl/flip_xform.sv
// Module flip_xform
// Conditionally inverts all bits except the flip bit, keyed by the flip
// bit of the input word. The operation is its own inverse, so one module
// serves both the encode path and the decode path. Combinational only.
// Assumes FLIP_POS < DATA_W.
module flip_xform #(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned FLIP_POS = DATA_W - 1
) (
    input  logic [DATA_W-1:0] word_in,
    output logic [DATA_W-1:0] word_out
);
    import flipmem_pkg::*;

    localparam logic [MAX_W-1:0] FULL_MASK = data_mask(FLIP_POS);
    localparam logic [DATA_W-1:0] INV_MASK = FULL_MASK[DATA_W-1:0];

    // Apply the inversion mask only when the key bit is set.
    always_comb begin
        word_out = word_in ^ (INV_MASK & {DATA_W{word_in[FLIP_POS]}});
    end
endmodule

// File: rtl/flip_storage.sv
// Module flip_storage
// Behavioural single-port array with a registered read port. A write and
// a read on the same edge return the word held before the write. Only the
// read register is reset; the array keeps its contents.
module flip_storage #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_word,
    output logic [DATA_W-1:0] rd_word
);
    logic [DATA_W-1:0] cells [DEPTH];

    // Array write port.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[addr] <= wr_word;
        end
    end

    // Registered read port with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_word <= '0;
        end else if (rd_en) begin
            rd_word <= cells[addr];
        end
    end
endmodule

// File: rtl/flipmem_top.sv
// Module flipmem_top
// Memory wrapper that stores data bits inverted whenever the flip bit of
// the written word is 1. The flip bit is stored as is and keys decoding on
// read. There is no flag column. Read latency is one cycle.
// Assumes FLIP_POS < DATA_W <= 64 and DEPTH >= 2.
module flipmem_top #(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned DEPTH    = 16,
    parameter int unsigned FLIP_POS = DATA_W - 1,
    localparam int unsigned ADDR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] raw_dbg
);
    logic [DATA_W-1:0] enc_word;
    logic [DATA_W-1:0] raw_word;

    // Encode path: flip data bits on the way into the array.
    flip_xform #(.DATA_W(DATA_W), .FLIP_POS(FLIP_POS)) u_enc (
        .word_in  (wr_data),
        .word_out (enc_word)
    );

    // Storage array with registered read port.
    flip_storage #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wr_word (enc_word),
        .rd_word (raw_word)
    );

    // Decode path: restore data bits keyed by the stored flip bit.
    flip_xform #(.DATA_W(DATA_W), .FLIP_POS(FLIP_POS)) u_dec (
        .word_in  (raw_word),
        .word_out (rd_data)
    );

    // Expose the raw stored word for inspection.
    always_comb begin
        raw_dbg = raw_word;
    end
endmodule

// File: rtl/flipmem_chk.sv
// Module flipmem_chk
// Assertion checker bound to flipmem_top. It watches the relation between
// the raw and decoded read outputs, and their behaviour on idle and reset.
module flipmem_chk #(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned FLIP_POS = DATA_W - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic [DATA_W-1:0] raw_dbg
);
    logic [DATA_W-1:0] inv_mask;

    // Reference mask, built independently of the design's package.
    always_comb begin
        inv_mask = '1;
        inv_mask[FLIP_POS] = 1'b0;
    end

    AST_FLIP_BIT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        raw_dbg[FLIP_POS] == rd_data[FLIP_POS]); // R3

    AST_INVERT_WHEN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        raw_dbg[FLIP_POS] |-> ((raw_dbg ^ rd_data) == inv_mask)); // R2

    AST_PLAIN_WHEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_dbg[FLIP_POS] |-> (raw_dbg == rd_data)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> ($stable(rd_data) && $stable(raw_dbg))); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0 && raw_dbg == '0)); // R7
endmodule

bind flipmem_top flipmem_chk #(.DATA_W(DATA_W), .FLIP_POS(FLIP_POS)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .raw_dbg (raw_dbg)
);

// File: tb/test_flipmem_top.sv
// Bench for flipmem_top: an 8-bit, 16-word configuration with the flip bit
// at position 5. It sweeps every word value across all addresses.
module test_flipmem_top;
    localparam int unsigned DW = 8;
    localparam int unsigned DEPTH = 16;
    localparam int unsigned FP = 5;
    localparam int unsigned AW = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic [DW-1:0] raw_dbg;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    flipmem_top #(.DATA_W(DW), .DEPTH(DEPTH), .FLIP_POS(FP)) i_flipmem_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .raw_dbg(raw_dbg)
    );

    function automatic logic [DW-1:0] expect_raw(input logic [DW-1:0] d);
        logic [DW-1:0] m;
        m = 8'hFF - (8'd1 << FP);
        return d[FP] ? (d ^ m) : d;
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R7 reset rd_data", rd_data, '0);
        check("R7 reset raw_dbg", raw_dbg, '0);
        rst_n = 1'b1;

        // R8: flip bit sits at FP, raw word width equals data width.
        checks++;
        if ($bits(raw_dbg) != DW) begin
            failures++;
            $display("FAIL R8 actual=%0d expected=%0d", $bits(raw_dbg), DW);
        end

        // R1 R2 R3 R4: every value through every address.
        for (int v = 0; v < 256; v++) begin
            logic [AW-1:0] a;
            a = AW'(v % DEPTH);
            do_write(a, 8'(v));
            do_read(a);
            check("R4 round trip", rd_data, 8'(v));
            if (v[FP]) check("R2 inverted storage", raw_dbg, expect_raw(8'(v)));
            else       check("R1 plain storage", raw_dbg, 8'(v));
            check("R3 flip bit kept", {7'd0, raw_dbg[FP]}, {7'd0, v[FP]});
        end

        // R4: all-zero and all-one words, with a neighbour written in between.
        do_write(4'd3, 8'h00);
        do_write(4'd4, 8'hFF);
        do_read(4'd3);
        check("R4 all zero", rd_data, 8'h00);
        do_read(4'd4);
        check("R4 all one", rd_data, 8'hFF);
        check("R2 all one raw", raw_dbg, 8'h20);

        // R5: same-address read and write on one edge returns old data.
        do_write(4'd7, 8'h5A);
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; addr = 4'd7; wr_data = 8'hE1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R5 old data", rd_data, 8'h5A);
        do_read(4'd7);
        check("R5 new data after", rd_data, 8'hE1);

        // R6: outputs hold while no read occurs, despite writes.
        do_write(4'd7, 8'h0F);
        do_write(4'd8, 8'hC3);
        check("R6 rd_data held", rd_data, 8'hE1);
        check("R6 raw held", raw_dbg, expect_raw(8'hE1));

        // R7: mid-run reset clears outputs but not the array.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R7 mid reset clear", rd_data, '0);
        do_read(4'd8);
        check("R7 array kept", rd_data, 8'hC3);

        // R4: scattered addresses with patterned data, written then read.
        for (int i = 0; i < DEPTH; i++) do_write(AW'(i), 8'((i * 37 + 11) & 8'hFF));
        for (int i = DEPTH - 1; i >= 0; i--) begin
            do_read(AW'(i));
            check("R4 sweep read", rd_data, 8'((i * 37 + 11) & 8'hFF));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule